// File: doc/BRIEF.md
# Wide Quotient Estimator

This unit estimates the quotient of a 128-bit unsigned dividend divided by a 64-bit unsigned divisor whose top bit is set. The estimate never falls below the truncated quotient and never exceeds it by more than two. A consumer that needs the exact quotient can finish the job with at most two compare-and-subtract steps. A dividend whose upper word is not below the divisor has a quotient too wide for 64 bits, and the unit then returns all ones.

The 64-bit quotient is built as two 32-bit halves. Each half is a 64-by-32 division by the upper half of the divisor, done on one shared serial restoring divider. After the upper half is estimated, the partial remainder is formed with a single multiply-subtract. A correction loop then steps the upper half down and adds the shifted divisor back until the remainder is no longer negative. The lower half is estimated from the middle 64 bits of that remainder. Either half is forced to 0xFFFFFFFF, without using the divider, when its 64-bit numerator would overflow a 32-bit quotient.

The caller pulses `start` while the unit is idle, with the operands on the inputs, and waits for the one-cycle `done` strobe. The operands are captured at start and need not be held.

Top module: `quot_estimator`

## Requirements
- R1: While reset is held and right after it is released, `busy` and `done` are low and `quotient` is zero.
- R2: A start is accepted when `start` is high in a cycle where `busy` is low. `busy` is high from the next cycle, `done` is high for exactly one cycle per accepted start, and `busy` is low in the cycle after `done`. At an accepted start, bit 63 of `divisor` must be 1.
- R3: A `start` pulse in a cycle where `busy` is high is ignored. The operation in flight completes with the operands it captured.
- R4: If the captured divisor is less than or equal to the dividend's upper word, `quotient` is all ones. `done` rises in the second cycle after the accepting clock edge.
- R5: Otherwise the quotient `q` satisfies t <= q <= t+2, where t is the truncated quotient of {dividendHi, dividendLo} by the divisor.
- R6: If the divisor exceeds the dividend's upper word but bits 63:32 of that word are at least bits 63:32 of the divisor, the upper estimate starts at 0xFFFFFFFF without a divide. The result then arrives within 100 cycles and still meets R5.
- R7: The lower half of the estimate is forced to 0xFFFFFFFF when bits 95:64 of the corrected remainder are at least the divisor's upper half. Otherwise it is the 64-by-32 quotient of remainder bits 95:32 by that upper half, and the result meets R5.
- R8: `quotient` keeps its value from the `done` cycle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new estimate |
| dividendHi | input | 64 | Upper word of the dividend |
| dividendLo | input | 64 | Lower word of the dividend |
| divisor | input | 64 | Divisor, bit 63 must be set |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| quotient | output | 64 | Quotient estimate |

## Verification
The assertions assume that every accepted start carries a divisor with its top bit set. They also assume the caller never relies on operands after the accepting edge. The bound properties on the estimate and on the correction count are only valid under that normalisation. The stimulus builds every divisor by forcing bit 63 high. Non-saturating cases reduce the upper dividend word below the divisor, while the saturating cases are chosen on purpose. Ignored starts carry different operands, so that accepting one by mistake would show up in the result.

// File: rtl/qest_pkg.sv
package qest_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVAL,
    ST_HIDIV,
    ST_MULSUB,
    ST_FIX,
    ST_LOEVAL,
    ST_LODIV,
    ST_DONE
  } estState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic ldOps;
    logic divGoHi;
    logic divGoLo;
    logic setHiSat;
    logic capHi;
    logic mulSub;
    logic fixStep;
    logic setLoSat;
    logic capLo;
    logic setAllOnes;
    logic report;
  } estCtl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic satAll;
    logic hiSat;
    logic remNeg;
    logic loSat;
    logic divFin;
  } estStat_t;

endpackage

// File: rtl/qest_halfdiv.sv
// Serial radix-2 restoring divider: W-bit numerator by H-bit denominator,
// one quotient bit per cycle, W cycles per use.
module qest_halfdiv #(
  parameter int W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             go,
  input  logic [W-1:0]     num,
  input  logic [W/2-1:0]   den,
  output logic [W/2-1:0]   quot,
  output logic             fin
);
  localparam int H  = W / 2;
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [H-1:0]  remReg;
  logic [H-1:0]  denReg;
  logic [W-1:0]  numShift;
  logic [CW-1:0] cnt;
  logic          running;

  logic [H:0]    trial;
  logic          ge;
  logic [H:0]    diff;

  always_comb begin
    trial = {remReg, numShift[W-1]};
    ge    = trial >= {1'b0, denReg};
    diff  = trial - {1'b0, denReg};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remReg   <= '0;
      denReg   <= '0;
      numShift <= '0;
      cnt      <= '0;
      running  <= 1'b0;
      fin      <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        remReg   <= '0;
        denReg   <= den;
        numShift <= num;
        cnt      <= '0;
        running  <= 1'b1;
      end else if (running) begin
        remReg   <= ge ? diff[H-1:0] : trial[H-1:0];
        numShift <= {numShift[W-2:0], ge};
        cnt      <= cnt + CW'(1);
        if (cnt == LAST) begin
          running <= 1'b0;
          fin     <= 1'b1;
        end
      end
    end
  end

  assign quot = numShift[H-1:0];

  // partial remainder always stays below the denominator
  assert_div_rem_R7: assert property (@(posedge clk) disable iff (!rstN)
    running |-> remReg < denReg);

  // the divider is never restarted while it is still working
  assert_div_go_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    go |-> !running);

endmodule

// File: rtl/qest_datapath.sv
module qest_datapath
  import qest_pkg::*;
#(
  parameter int W = 64
) (
  input  logic           clk,
  input  logic           rstN,
  input  estCtl_t        ctl,
  input  logic [W-1:0]   dividendHi,
  input  logic [W-1:0]   dividendLo,
  input  logic [W-1:0]   divisor,
  output estStat_t       stat,
  output logic [W-1:0]   quotient
);
  localparam int H = W / 2;

  logic [W-1:0]   opHi, opLo, dvs;
  logic [H-1:0]   zHi, zLo;
  logic [2*W-1:0] rem;

  logic [H-1:0]   dvsHi;
  logic [W+H-1:0] prod;
  logic [2*W-1:0] remSub, remAdd;
  logic [W-1:0]   mid;
  logic [W-1:0]   divNum;
  logic [H-1:0]   divQ;
  logic           divFin;

  always_comb begin
    dvsHi  = dvs[W-1:H];
    prod   = {{H{1'b0}}, dvs} * {{W{1'b0}}, zHi};
    remSub = {opHi, opLo} - {prod, {H{1'b0}}};
    remAdd = rem + {{H{1'b0}}, dvs, {H{1'b0}}};
    mid    = rem[W+H-1:H];
    divNum = ctl.divGoLo ? mid : opHi;
  end

  qest_halfdiv #(.W(W)) i_halfdiv (
    .clk  (clk),
    .rstN (rstN),
    .go   (ctl.divGoHi | ctl.divGoLo),
    .num  (divNum),
    .den  (dvsHi),
    .quot (divQ),
    .fin  (divFin)
  );

  always_comb begin
    stat.satAll = dvs <= opHi;
    stat.hiSat  = opHi[W-1:H] >= dvsHi;
    stat.remNeg = rem[2*W-1];
    stat.loSat  = mid[W-1:H] >= dvsHi;
    stat.divFin = divFin;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opHi <= '0;
      opLo <= '0;
      dvs  <= '0;
      zHi  <= '0;
      zLo  <= '0;
      rem  <= '0;
    end else begin
      if (ctl.ldOps) begin
        opHi <= dividendHi;
        opLo <= dividendLo;
        dvs  <= divisor;
      end
      if (ctl.setAllOnes) begin
        zHi <= '1;
        zLo <= '1;
      end
      if (ctl.setHiSat) zHi <= '1;
      if (ctl.capHi)    zHi <= divQ;
      if (ctl.fixStep)  zHi <= zHi - H'(1);
      if (ctl.setLoSat) zLo <= '1;
      if (ctl.capLo)    zLo <= divQ;
      if (ctl.mulSub)   rem <= remSub;
      if (ctl.fixStep)  rem <= remAdd;
    end
  end

  assign quotient = {zHi, zLo};

  // ---------------- assertions ----------------
  logic [2*W+1:0] wideN, wideB, wideQB;
  always_comb begin
    wideN  = {2'b00, opHi, opLo};
    wideB  = {{(W+2){1'b0}}, dvs};
    wideQB = {{(W+2){1'b0}}, quotient} * wideB;
  end

  // accepted divisors are normalised
  assert_divisor_norm_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ldOps |-> divisor[W-1]);

  // overflowing quotient reports all ones
  assert_sat_ones_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.report && stat.satAll) |-> (&quotient));

  // estimate never below the truncated quotient
  assert_est_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.report && !stat.satAll) |-> (wideQB + wideB > wideN));

  // estimate at most two above the truncated quotient
  assert_est_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.report && !stat.satAll) |-> (wideQB <= wideN + wideB + wideB));

endmodule

// File: rtl/qest_control.sv
module qest_control
  import qest_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  estStat_t  stat,
  output estCtl_t   ctl,
  output logic      busy,
  output logic      done
);
  estState_t state, nxt;
  logic [1:0] fixCnt;

  always_comb begin
    ctl = '0;
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.ldOps = 1'b1;
          nxt = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (stat.satAll) begin
          ctl.setAllOnes = 1'b1;
          nxt = ST_DONE;
        end else if (stat.hiSat) begin
          ctl.setHiSat = 1'b1;
          nxt = ST_MULSUB;
        end else begin
          ctl.divGoHi = 1'b1;
          nxt = ST_HIDIV;
        end
      end
      ST_HIDIV: begin
        if (stat.divFin) begin
          ctl.capHi = 1'b1;
          nxt = ST_MULSUB;
        end
      end
      ST_MULSUB: begin
        ctl.mulSub = 1'b1;
        nxt = ST_FIX;
      end
      ST_FIX: begin
        if (stat.remNeg) ctl.fixStep = 1'b1;
        else             nxt = ST_LOEVAL;
      end
      ST_LOEVAL: begin
        if (stat.loSat) begin
          ctl.setLoSat = 1'b1;
          nxt = ST_DONE;
        end else begin
          ctl.divGoLo = 1'b1;
          nxt = ST_LODIV;
        end
      end
      ST_LODIV: begin
        if (stat.divFin) begin
          ctl.capLo = 1'b1;
          nxt = ST_DONE;
        end
      end
      ST_DONE: begin
        ctl.report = 1'b1;
        nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  // correction step counter, observed only by the bound check below
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            fixCnt <= '0;
    else if (ctl.ldOps)                   fixCnt <= '0;
    else if (ctl.fixStep && fixCnt != 2'd3) fixCnt <= fixCnt + 2'd1;
  end

  // done is a single-cycle strobe
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // the add-back loop never needs more than two steps
  assert_fix_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fixStep |-> fixCnt < 2'd2);

  // a start seen while busy does not reload the operands
  assert_ignore_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |-> !ctl.ldOps);

endmodule

// File: rtl/quot_estimator.sv
module quot_estimator
  import qest_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] dividendHi,
  input  logic [W-1:0] dividendLo,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient
);
  estCtl_t  ctl;
  estStat_t stat;

  qest_control i_control (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .stat  (stat),
    .ctl   (ctl),
    .busy  (busy),
    .done  (done)
  );

  qest_datapath #(.W(W)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .dividendHi (dividendHi),
    .dividendLo (dividendLo),
    .divisor    (divisor),
    .stat       (stat),
    .quotient   (quotient)
  );

endmodule

// File: tb/test_quot_estimator.sv
`timescale 1ns/1ps
module test_quot_estimator;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [63:0] dividendHi = '0, dividendLo = '0, divisor = '0;
  logic        busy, done;
  logic [63:0] quotient;

  always #2 clk = ~clk;

  quot_estimator i_quot_estimator (
    .clk(clk), .rstN(rstN), .start(start),
    .dividendHi(dividendHi), .dividendLo(dividendLo), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient)
  );

  typedef struct { logic [63:0] hi, lo, dv; } item_t;
  item_t sb[$];

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] nextRand(input logic [63:0] s);
    logic [63:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  // driver: applies one operation, pushes the expectation, waits for done
  task automatic runOp(input logic [63:0] hi, lo, dv, input bit poke,
                       output int lat, output logic [63:0] qOut);
    item_t it;
    while (busy) @(negedge clk);
    dividendHi = hi; dividendLo = lo; divisor = dv; start = 1'b1;
    it.hi = hi; it.lo = lo; it.dv = dv;
    sb.push_back(it);
    lat = 0;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done) begin
      if (poke && lat == 3) begin
        // R3: start while busy with operands that would saturate
        dividendHi = '1; dividendLo = '1; divisor = 64'h8000_0000_0000_0000;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    qOut = quotient;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R2 busy/done after done",
          {62'b0, busy, done}, 64'd0);
  endtask

  // monitor: pops expectations when results appear
  initial begin
    bit prevDone = 1'b0;
    forever begin
      @(negedge clk);
      if (done && prevDone)
        check(1'b0, "R2 done longer than one cycle", 64'd1, 64'd0);
      if (done && !prevDone) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2 unexpected done", quotient, 64'd0);
        end else begin
          item_t it;
          logic [127:0] t;
          it = sb.pop_front();
          if (it.hi >= it.dv) begin
            check(quotient == '1, "R4 saturation", quotient, '1);
          end else begin
            t = {it.hi, it.lo} / {64'd0, it.dv};
            // R5 R6 R7: estimate within [t, t+2]
            check(quotient >= t[63:0] && (quotient - t[63:0]) <= 64'd2,
                  "R5 R7 estimate range", quotient, t[63:0]);
          end
        end
      end
      prevDone = done;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [63:0] q, hi, lo, dv;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(busy == 1'b0, "R1 busy in reset", {63'b0, busy}, 64'd0);
    check(done == 1'b0, "R1 done in reset", {63'b0, done}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(quotient == 64'd0, "R1 quotient after reset", quotient, 64'd0);
    check(busy == 1'b0 && done == 1'b0, "R1 flags after reset",
          {62'b0, busy, done}, 64'd0);

    // R4: divisor equal to and below the upper word
    runOp(64'h9000_0000_0000_0000, 64'h1234, 64'h9000_0000_0000_0000, 1'b0, lat, q);
    check(lat == 2, "R4 latency equal case", 64'(lat), 64'd2);
    runOp(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h8000_0000_0000_0000, 1'b0, lat, q);
    check(lat == 2, "R4 latency greater case", 64'(lat), 64'd2);

    // R6: upper half saturates, no first divide
    runOp(64'h8000_0000_1234_5678, 64'hDEAD_BEEF_0BAD_F00D,
          64'h8000_0000_FFFF_FFFF, 1'b0, lat, q);
    check(lat < 100, "R6 short latency", 64'(lat), 64'd100);

    // corner vectors
    runOp(64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 1'b0, lat, q);
    runOp(64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, lat, q);
    runOp(64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_FFFF_FFFF, 1'b0, lat, q);
    runOp(64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 1'b0, lat, q);

    // R3: start pulse while busy is ignored
    runOp(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321,
          64'hC000_0000_0000_0001, 1'b1, lat, q);

    // R8: result holds until next start
    repeat (5) @(negedge clk);
    check(quotient == q, "R8 quotient hold", quotient, q);

    // random normalised operands
    for (int i = 0; i < 24; i++) begin
      seed = nextRand(seed); dv = seed | 64'h8000_0000_0000_0000;
      seed = nextRand(seed); hi = seed;
      if (hi >= dv) hi = hi - dv;
      seed = nextRand(seed); lo = seed;
      runOp(hi, lo, dv, 1'b0, lat, q);
    end

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R2 all results returned", 64'(sb.size()), 64'd0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule